// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port of up to 32 pins behind a 32-bit register interface. Software drives pins through an output data register, picks per-pin direction through a direction register, and updates individual outputs without read-modify-write through write-only set, clear and invert aliases. Pin levels are brought into the clock domain by a synchroniser chain and can be read back at any time.

Each pin owns a control word holding a 4-bit interrupt mode. The mode selects rising, falling or either edge detection, or level-high or level-low detection. Detected events latch into a shared flag register. Software clears that register by writing ones. A single registered interrupt line is high while any flag is set.

The register space is split by address bit 8. When that bit is 0, the address selects the data registers. When it is 1, it selects the control region, which holds the per-pin control words and the flag register. Reads return their data in the same cycle. Writes take effect at the next clock edge.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, pin_out, pin_oe and irq_out are 0, the flag register (control region 0xA0) reads 0, and every pin control word reads 0.
- R2: Writing data-region offset 0x00 loads the output data register. Offset 0x14 loads the direction register. Both read back the last value written. pin_out equals the output data register and pin_oe equals the direction register, where 1 means the pin drives.
- R3: Writing data-region offset 0x04 sets every output bit written as 1 and leaves bits written as 0 unchanged. Reading this offset returns 0.
- R4: Writing data-region offset 0x08 clears every output bit written as 1 and leaves the others unchanged. Reading this offset returns 0.
- R5: Writing data-region offset 0x0C inverts every output bit written as 1 and leaves the others unchanged. Reading this offset returns 0.
- R6: Data-region offset 0x10 returns the pin levels through a two-flop synchroniser. A change applied before clock edge k reads back after edge k+1.
- R7: Pin n's control word sits at control-region offset 4·n. Only its mode field, bits 19:16, is stored, and all other bits read as 0.
- R8: Mode 0x9 flags a rising edge, mode 0xA flags a falling edge and mode 0xB flags either edge. A pin change applied before edge k sets the flag at edge k+2.
- R9: Mode 0xC (level high) and mode 0x8 (level low) set the flag on every cycle the level is active, so a clear write during an active level leaves the flag set.
- R10: Writing the flag register clears each flag bit written as 1 and leaves flag bits written as 0 unchanged.
- R11: When a clear write and a new event for the same pin land on the same clock edge, the flag stays set.
- R12: irq_out is the OR of all flags, registered. It rises one cycle after a flag is set and falls one cycle after the last flag clears.
- R13: Mode 0x0 and every code other than 0x8–0xC never set a flag. Writing 0 to a control word stops further events for that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Byte address; bit 8 selects the control region |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output data driven to the pads |
| pin_oe | output | NPINS | Per-pin output enable |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
The assertions assume that reg_addr and reg_wdata are stable and known whenever reg_we is high, and that the written addresses are aligned to 4 bytes. The bench drives all register inputs at the falling clock edge and writes only to aligned offsets. The bench changes pin_in on falling edges, one pin at a time in the interrupt tests, so that the edge on which each event lands is known. It times the clear-versus-event collision by counting edges from the pin change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned CTRL_SEL_BIT = 8;

   localparam logic [7:0] OFF_DOUT = 8'h00;
   localparam logic [7:0] OFF_SET  = 8'h04;
   localparam logic [7:0] OFF_CLR  = 8'h08;
   localparam logic [7:0] OFF_TGL  = 8'h0C;
   localparam logic [7:0] OFF_DIN  = 8'h10;
   localparam logic [7:0] OFF_DIR  = 8'h14;
   localparam logic [7:0] OFF_FLAG = 8'hA0;

   localparam int unsigned MODE_LSB = 16;

   localparam logic [3:0] MODE_OFF    = 4'h0;
   localparam logic [3:0] MODE_LVL_LO = 4'h8;
   localparam logic [3:0] MODE_RISE   = 4'h9;
   localparam logic [3:0] MODE_FALL   = 4'hA;
   localparam logic [3:0] MODE_BOTH   = 4'hB;
   localparam logic [3:0] MODE_LVL_HI = 4'hC;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_depth
      $error("gpio_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
   import gpio_port_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] mode,
   input  logic       lvl,
   input  logic       lvl_d,
   input  logic       clr,
   output logic       flag
);
   logic evt;
   logic armed;

   always_comb begin
      evt   = 1'b0;
      armed = 1'b1;
      case (mode)
         MODE_LVL_LO: evt = !lvl;
         MODE_RISE:   evt = lvl & !lvl_d;
         MODE_FALL:   evt = !lvl & lvl_d;
         MODE_BOTH:   evt = lvl ^ lvl_d;
         MODE_LVL_HI: evt = lvl;
         default:     armed = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= (flag & !clr) | evt;
   end

   p_disabled_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !$rose(flag));
   p_clear_takes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt) |=> !flag);
   p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag);
   p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_LVL_HI && lvl) |=> flag);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_port_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [8:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic             irq_out
);
   localparam int IDX_W = 5;

   if (NPINS < 1 || NPINS > 32) begin : g_bad_pins
      $error("gpio_irq_port: NPINS must be 1..32");
   end

   logic             in_ctl;
   logic [7:0]       off;
   logic             aligned;
   logic [IDX_W-1:0] pidx;
   logic             pin_word;
   logic             flag_wr;

   logic [NPINS-1:0] dout_q, dir_q, lvl, lvl_d, flags;
   logic [3:0]       mode_q [NPINS];
   logic [NPINS-1:0] wmask;

   assign in_ctl   = reg_addr[CTRL_SEL_BIT];
   assign off      = reg_addr[7:0];
   assign aligned  = (off[1:0] == 2'b00);
   assign pidx     = off[6:2];
   assign pin_word = in_ctl && !off[7] && aligned && (int'(pidx) < NPINS);
   assign flag_wr  = reg_we && in_ctl && (off == OFF_FLAG);
   assign wmask    = reg_wdata[NPINS-1:0];

   // data region registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout_q <= '0;
         dir_q  <= '0;
      end else if (reg_we && !in_ctl) begin
         case (off)
            OFF_DOUT: dout_q <= wmask;
            OFF_SET:  dout_q <= dout_q | wmask;
            OFF_CLR:  dout_q <= dout_q & ~wmask;
            OFF_TGL:  dout_q <= dout_q ^ wmask;
            OFF_DIR:  dir_q  <= wmask;
            default:  ;
         endcase
      end
   end

   assign pin_out = dout_q;
   assign pin_oe  = dir_q;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_d <= '0;
      else        lvl_d <= lvl;
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      always_ff @(posedge clk) begin
         if (!rst_n)
            mode_q[i] <= MODE_OFF;
         else if (reg_we && pin_word && int'(pidx) == i)
            mode_q[i] <= reg_wdata[MODE_LSB +: 4];
      end

      gpio_pin_detect u_det (
         .clk   (clk),
         .rst_n (rst_n),
         .mode  (mode_q[i]),
         .lvl   (lvl[i]),
         .lvl_d (lvl_d[i]),
         .clr   (flag_wr && reg_wdata[i]),
         .flag  (flags[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_out <= 1'b0;
      else        irq_out <= |flags;
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (!in_ctl) begin
         case (off)
            OFF_DOUT: reg_rdata = 32'(dout_q);
            OFF_DIN:  reg_rdata = 32'(lvl);
            OFF_DIR:  reg_rdata = 32'(dir_q);
            default:  reg_rdata = '0;
         endcase
      end else if (pin_word) begin
         reg_rdata[MODE_LSB +: 4] = mode_q[pidx];
      end else if (off == OFF_FLAG) begin
         reg_rdata = 32'(flags);
      end
   end

   p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !in_ctl && off == OFF_SET)
      |=> ((pin_out & $past(wmask)) == $past(wmask)));
   p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !in_ctl && off == OFF_CLR)
      |=> ((pin_out & $past(wmask)) == '0));
   p_irq_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $past(flags != '0));
   p_irq_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_out) |-> $past(flags == '0));
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [8:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic        irq_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] m_out = '0, m_dir = '0, v;

   localparam logic [8:0] CTL = 9'h100;

   always #5 clk = ~clk;

   gpio_irq_port u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out));

   function automatic logic [31:0] alias_next(logic [31:0] cur, int op, logic [31:0] d);
      case (op)
         0: return d;
         1: return cur | d;
         2: return cur & ~d;
         3: return cur ^ d;
         default: return cur;
      endcase
   endfunction

   function automatic logic [8:0] op_addr(int op);
      case (op)
         0: return 9'h000;
         1: return 9'h004;
         2: return 9'h008;
         3: return 9'h00C;
         default: return 9'h014;
      endcase
   endfunction

   function automatic logic [8:0] ctl_addr(int pin);
      return CTL + 9'(pin * 4);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [8:0] a, logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [8:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      report();
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);

      // R1 reset state
      chk("R1 pin_out", pin_out, 0);
      chk("R1 pin_oe", pin_oe, 0);
      chk("R1 irq_out", {31'b0, irq_out}, 0);
      rd(CTL + 9'hA0, v); chk("R1 flags", v, 0);
      rd(ctl_addr(5), v); chk("R1 ctrl word", v, 0);

      // R2 data and direction
      wr(9'h000, 32'hA5A5_0F0F); m_out = 32'hA5A5_0F0F;
      rd(9'h000, v); chk("R2 dout readback", v, m_out);
      chk("R2 pin_out", pin_out, m_out);
      wr(9'h014, 32'h0000_FFFF); m_dir = 32'h0000_FFFF;
      rd(9'h014, v); chk("R2 dir readback", v, m_dir);
      chk("R2 pin_oe", pin_oe, m_dir);

      // R3 R4 R5 aliases
      wr(9'h004, 32'h0000_00F0); m_out = alias_next(m_out, 1, 32'h0000_00F0);
      chk("R3 set alias", pin_out, m_out);
      rd(9'h004, v); chk("R3 set reads zero", v, 0);
      wr(9'h008, 32'hA000_0001); m_out = alias_next(m_out, 2, 32'hA000_0001);
      chk("R4 clear alias", pin_out, m_out);
      rd(9'h008, v); chk("R4 clear reads zero", v, 0);
      wr(9'h00C, 32'hFFFF_0000); m_out = alias_next(m_out, 3, 32'hFFFF_0000);
      chk("R5 toggle alias", pin_out, m_out);
      rd(9'h00C, v); chk("R5 toggle reads zero", v, 0);

      // R2 R3 R4 R5 random mix
      for (int k = 0; k < 200; k++) begin
         int op;
         logic [31:0] d;
         op = int'($urandom % 5);
         d  = $urandom;
         wr(op_addr(op), d);
         if (op == 4) m_dir = d;
         else         m_out = alias_next(m_out, op, d);
         chk("R2/R3/R4/R5 random pin_out", pin_out, m_out);
         chk("R2 random pin_oe", pin_oe, m_dir);
      end

      // R6 synchroniser latency
      for (int k = 0; k < 8; k++) begin
         logic [31:0] prev, nv;
         rd(9'h010, prev);
         nv = $urandom;
         pin_in = nv;
         wait_n(1);
         rd(9'h010, v); chk("R6 one edge still old", v, prev);
         wait_n(1);
         rd(9'h010, v); chk("R6 two edges new", v, nv);
      end
      pin_in = '0;
      wait_n(4);
      rd(CTL + 9'hA0, v); chk("R13 modes off no flags", v, 0);

      // R7 control word
      wr(ctl_addr(7), 32'hFFFF_FFFF);
      rd(ctl_addr(7), v); chk("R7 mode field only", v, 32'h000F_0000);
      wr(ctl_addr(7), 32'h0);
      rd(ctl_addr(7), v); chk("R7 cleared", v, 0);

      // R8 rising on pin 3, R12 irq timing
      wr(ctl_addr(3), 32'h0009_0000);
      pin_in[3] = 1'b1;
      wait_n(2);
      rd(CTL + 9'hA0, v); chk("R8 flag not before k+2", v, 0);
      wait_n(1);
      rd(CTL + 9'hA0, v); chk("R8 rising flag", v, 32'h8);
      chk("R12 irq one cycle later", {31'b0, irq_out}, 0);
      wait_n(1);
      chk("R12 irq high", {31'b0, irq_out}, 1);
      wr(CTL + 9'hA0, 32'h8);
      rd(CTL + 9'hA0, v); chk("R10 flag cleared", v, 0);
      chk("R12 irq lags clear", {31'b0, irq_out}, 1);
      wait_n(1);
      chk("R12 irq low", {31'b0, irq_out}, 0);
      pin_in[3] = 1'b0;
      wait_n(4);
      rd(CTL + 9'hA0, v); chk("R8 rising ignores fall", v, 0);

      // R8 falling on pin 4
      wr(ctl_addr(4), 32'h000A_0000);
      pin_in[4] = 1'b1; wait_n(4);
      rd(CTL + 9'hA0, v); chk("R8 falling ignores rise", v, 0);
      pin_in[4] = 1'b0; wait_n(4);
      rd(CTL + 9'hA0, v); chk("R8 falling flag", v, 32'h10);
      wr(CTL + 9'hA0, 32'hFFFF_FFFF);

      // R8 either on pin 5, R11 collision
      wr(ctl_addr(5), 32'h000B_0000);
      pin_in[5] = 1'b1; wait_n(4);
      rd(CTL + 9'hA0, v); chk("R8 either rise", v, 32'h20);
      wr(CTL + 9'hA0, 32'h20);
      rd(CTL + 9'hA0, v); chk("R10 either cleared", v, 0);
      pin_in[5] = 1'b0; wait_n(4);
      rd(CTL + 9'hA0, v); chk("R8 either fall", v, 32'h20);
      pin_in[5] = 1'b1; wait_n(2);
      wr(CTL + 9'hA0, 32'h20);
      rd(CTL + 9'hA0, v); chk("R11 event beats clear", v, 32'h20);
      wr(CTL + 9'hA0, 32'h20);
      rd(CTL + 9'hA0, v); chk("R11 later clear works", v, 0);
      wr(ctl_addr(5), 32'h0);
      pin_in[5] = 1'b0; wait_n(4);

      // R9 level high pin 6
      wr(ctl_addr(6), 32'h000C_0000);
      pin_in[6] = 1'b1; wait_n(4);
      wr(CTL + 9'hA0, 32'h40);
      rd(CTL + 9'hA0, v); chk("R9 level high persists", v, 32'h40);
      pin_in[6] = 1'b0; wait_n(3);
      wr(CTL + 9'hA0, 32'h40);
      rd(CTL + 9'hA0, v); chk("R9 level gone clears", v, 0);

      // R9 level low pin 8, R13 disable by zero write
      wr(ctl_addr(8), 32'h0008_0000);
      wait_n(2);
      rd(CTL + 9'hA0, v); chk("R9 level low flag", v, 32'h100);
      wr(ctl_addr(8), 32'h0);
      wr(CTL + 9'hA0, 32'h100);
      wait_n(2);
      rd(CTL + 9'hA0, v); chk("R13 zero write disables", v, 0);

      // R13 reserved code on pin 9
      wr(ctl_addr(9), 32'h000D_0000);
      for (int k = 0; k < 4; k++) begin
         pin_in[9] = ~pin_in[9];
         wait_n(4);
      end
      rd(CTL + 9'hA0, v); chk("R13 reserved code quiet", v, 0);
      chk("R13 irq stays low", {31'b0, irq_out}, 0);

      // R10 selective clear
      wr(ctl_addr(10), 32'h0009_0000);
      pin_in[3] = 1'b1; pin_in[10] = 1'b1;
      wait_n(4);
      rd(CTL + 9'hA0, v); chk("R10 two flags", v, 32'h408);
      wr(CTL + 9'hA0, 32'h8);
      rd(CTL + 9'hA0, v); chk("R10 zero bits kept", v, 32'h400);
      wr(CTL + 9'hA0, 32'hFFFF_FFFF);
      rd(CTL + 9'hA0, v); chk("R10 all ones clears", v, 0);
      wait_n(1);
      chk("R12 irq low at end", {31'b0, irq_out}, 0);

      report();
   end
endmodule